// File: doc/BRIEF.md
# Write Burst Byte-Lane Strobe Legalizer

This block turns caller-supplied write strobes into strobes that obey the AXI byte-lane rules for a write burst. A burst is opened with a command that gives its start address, transfer size, burst type, length and a correction-enable bit. The caller then presents one strobe per beat. For each beat the block works out which byte lanes of the data bus the protocol allows. It emits the caller's strobe masked down to those lanes. When correction is off, it emits the caller's strobe as given.

If the caller offers all-ones strobes, the output is exactly the legal lane pattern, so the block also serves as a plain strobe generator. Narrow transfers, unaligned start addresses and the FIXED, INCR and WRAP burst types are handled. Beats enter through one valid/ready handshake and leave through a registered valid/ready output that carries a last-beat flag.

Top module: `wstrb_legalizer`

## Requirements
- R1: With correction enabled, each output strobe equals the beat's input strobe ANDed with that beat's legal lane mask.
- R2: With correction disabled (`cmd_fix` = 0 when the command is taken), each output strobe equals the beat's input strobe unchanged.
- R3: With correction enabled and an all-ones input strobe, the output strobe equals the legal lane mask exactly.
- R4: The first beat enables lanes from the start address's lane (start address modulo bus bytes) up to the last lane of the size-aligned container holding it. For example, bus 4 bytes, start 0x01, size 1 gives 4'b0010.
- R5: For INCR bursts, beat n>0 uses address (start aligned down to the size) + n * 2^size, and its lanes are that address modulo bus bytes through the end of the transfer. Size is log2 of bytes per beat. `cmd_burst` encodes FIXED=0, INCR=1, WRAP=2.
- R6: For FIXED bursts, every beat uses the first beat's lane mask.
- R7: For WRAP bursts, addresses wrap inside a window of (len+1) * 2^size bytes aligned to its own size. For example, size 0, len 1, start 0x03 gives masks 4'b1000 then 4'b0100.
- R8: `cmd_len` is beats minus one. `out_last` is set on the beat whose index equals `cmd_len`, and `cmd_ready` is low while a burst is open and high again the cycle after its last beat is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_strb`, `out_last` and `out_valid` hold, and no further input beat is accepted.
- R10: After reset, `cmd_ready` is 1 and `out_valid` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP |
| cmd_len | input | LEN_W | Number of beats minus one |
| cmd_fix | input | 1 | 1 masks strobes to legal lanes, 0 passes them through |
| in_valid | input | 1 | Caller beat strobe offered |
| in_ready | output | 1 | Beat strobe accepted when valid |
| in_strb | input | BUS_BYTES | Caller strobe for the beat |
| out_valid | output | 1 | Legalized strobe available |
| out_ready | input | 1 | Downstream takes the strobe |
| out_strb | output | BUS_BYTES | Legalized strobe |
| out_last | output | 1 | Strobe belongs to the final beat |

## Verification
The wrap-around case is the hardest to see from the ports. Lanes are taken modulo the bus width, so a wrap window of a whole bus width or more gives the same lanes as INCR. The stimulus therefore uses a two-beat byte-sized WRAP burst that starts in the last lane, where a wrap and an increment lead to different lanes. Backpressure is randomized on every cycle, so stalls fall on final beats and on the first beat after a new command, and the monitor compares each held output against the previous cycle.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/wsl_addr_gen.sv
module wsl_addr_gen
  import wsl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int SIZE_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [2:0]        ld_size,
  input  burst_e            ld_burst,
  input  logic [LEN_W-1:0]  ld_len,
  output logic [SIZE_MAX-1:0] cur_lo,
  output logic [2:0]        cur_size
);
  localparam logic [2:0] SIZE_CAP = 3'(SIZE_MAX);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ADDR_W-1:0] wlo_q, wlo_n;
  logic [ADDR_W-1:0] wbytes_q, wbytes_n;
  logic [2:0]        size_q, size_n;
  burst_e            burst_q, burst_n;

  logic [2:0]        ld_eff;
  logic [ADDR_W-1:0] nbytes, aligned, incr;

  always_comb begin
    ld_eff  = (ld_size > SIZE_CAP) ? SIZE_CAP : ld_size;
    nbytes  = ADDR_W'(1) << size_q;
    aligned = addr_q & ~(nbytes - ADDR_W'(1));
    incr    = aligned + nbytes;

    addr_n   = addr_q;
    wlo_n    = wlo_q;
    wbytes_n = wbytes_q;
    size_n   = size_q;
    burst_n  = burst_q;

    if (load) begin
      addr_n   = ld_addr;
      size_n   = ld_eff;
      burst_n  = ld_burst;
      wbytes_n = (ADDR_W'(ld_len) + ADDR_W'(1)) << ld_eff;
      wlo_n    = ld_addr & ~(((ADDR_W'(ld_len) + ADDR_W'(1)) << ld_eff) - ADDR_W'(1));
    end else if (step) begin
      unique case (burst_q)
        BURST_FIXED: addr_n = addr_q;
        BURST_WRAP:  addr_n = (incr == wlo_q + wbytes_q) ? wlo_q : incr;
        default:     addr_n = incr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wlo_q    <= '0;
      wbytes_q <= '0;
      size_q   <= '0;
      burst_q  <= BURST_INCR;
    end else if (load || step) begin
      addr_q   <= addr_n;
      wlo_q    <= wlo_n;
      wbytes_q <= wbytes_n;
      size_q   <= size_n;
      burst_q  <= burst_n;
    end
  end

  assign cur_lo   = addr_q[SIZE_MAX-1:0];
  assign cur_size = size_q;

  AST_FIXED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && burst_q == BURST_FIXED) |=> $stable(addr_q)); // R6

  AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && burst_q == BURST_WRAP && (addr_q - wlo_q) < wbytes_q)
      |=> ((addr_q - wlo_q) < wbytes_q)); // R7
endmodule

// File: rtl/wsl_lane_mask.sv
module wsl_lane_mask #(
  parameter int BUS_BYTES = 4,
  parameter int LB        = $clog2(BUS_BYTES)
) (
  input  logic [LB-1:0]        addr_lo,
  input  logic [2:0]           size,
  output logic [BUS_BYTES-1:0] mask
);
  logic [LB:0] nb, lo, base, hi;

  always_comb begin
    nb   = (LB+1)'(1) << size;
    lo   = {1'b0, addr_lo};
    base = {1'b0, addr_lo & ~(nb[LB-1:0] - LB'(1))};
    hi   = base + nb - (LB+1)'(1);
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign mask[i] = ((LB+1)'(i) >= lo) && ((LB+1)'(i) <= hi);
  end
endmodule

// File: rtl/wstrb_legalizer.sv
module wstrb_legalizer
  import wsl_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [2:0]           cmd_size,
  input  logic [1:0]           cmd_burst,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 cmd_fix,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUS_BYTES-1:0] in_strb,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BUS_BYTES-1:0] out_strb,
  output logic                 out_last
);
  localparam int LB = $clog2(BUS_BYTES);

  logic                 busy_q, busy_n;
  logic [LEN_W-1:0]     cnt_q, cnt_n;
  logic [LEN_W-1:0]     len_q, len_n;
  logic                 fix_q, fix_n;
  logic                 ov_q, ov_n;
  logic [BUS_BYTES-1:0] ostrb_q, ostrb_n;
  logic                 olast_q, olast_n;

  logic                 cmd_go, beat_go, is_last;
  logic [LB-1:0]        cur_lo;
  logic [2:0]           cur_size;
  logic [BUS_BYTES-1:0] lane_mask;

  wsl_addr_gen #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .SIZE_MAX(LB)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_go),
    .step    (beat_go),
    .ld_addr (cmd_addr),
    .ld_size (cmd_size),
    .ld_burst(burst_e'(cmd_burst)),
    .ld_len  (cmd_len),
    .cur_lo  (cur_lo),
    .cur_size(cur_size)
  );

  wsl_lane_mask #(
    .BUS_BYTES(BUS_BYTES),
    .LB       (LB)
  ) u_mask (
    .addr_lo(cur_lo),
    .size   (cur_size),
    .mask   (lane_mask)
  );

  assign cmd_ready = !busy_q;
  assign in_ready  = busy_q && (!ov_q || out_ready);
  assign cmd_go    = cmd_valid && !busy_q;
  assign beat_go   = in_valid && in_ready;
  assign is_last   = (cnt_q == len_q);

  always_comb begin
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    fix_n   = fix_q;
    ov_n    = ov_q;
    ostrb_n = ostrb_q;
    olast_n = olast_q;

    if (cmd_go) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      len_n  = cmd_len;
      fix_n  = cmd_fix;
    end else if (beat_go) begin
      cnt_n  = cnt_q + LEN_W'(1);
      busy_n = !is_last;
    end

    if (beat_go) begin
      ov_n    = 1'b1;
      ostrb_n = fix_q ? (in_strb & lane_mask) : in_strb;
      olast_n = is_last;
    end else if (out_ready) begin
      ov_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      fix_q   <= 1'b0;
      ov_q    <= 1'b0;
      ostrb_q <= '0;
      olast_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ov_q   <= ov_n;
      if (cmd_go || beat_go) begin
        cnt_q <= cnt_n;
      end
      if (cmd_go) begin
        len_q <= len_n;
        fix_q <= fix_n;
      end
      if (beat_go) begin
        ostrb_q <= ostrb_n;
        olast_q <= olast_n;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_strb  = ostrb_q;
  assign out_last  = olast_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(out_strb) && $stable(out_last))); // R9

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && !fix_q) |=> (out_strb == $past(in_strb))); // R2

  AST_FIX_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && fix_q) |=> ((out_strb & ~$past(in_strb)) == '0)); // R1

  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && is_last) |=> (cmd_ready && out_last)); // R8

  AST_MASK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (lane_mask != '0 && $countones(lane_mask) <= (1 << cur_size))); // R4
endmodule

// File: tb/wstrb_legalizer_test.sv
module wstrb_legalizer_test;
  localparam int BB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_burst = '0;
  logic [7:0]  cmd_len = '0;
  logic        cmd_fix = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_strb = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_strb;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  wstrb_legalizer #(.BUS_BYTES(BB), .ADDR_W(32), .LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_size(cmd_size), .cmd_burst(cmd_burst), .cmd_len(cmd_len), .cmd_fix(cmd_fix),
    .in_valid(in_valid), .in_ready(in_ready), .in_strb(in_strb),
    .out_valid(out_valid), .out_ready(out_ready), .out_strb(out_strb), .out_last(out_last)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected lane mask from the requirements (R4..R7)
  function automatic logic [3:0] legal(input int start, input int size, input int burst,
                                       input int len, input int n);
    int sz = (size > 2) ? 2 : size;
    int nb = 1 << sz;
    int al = start - (start % nb);
    int wb = nb * (len + 1);
    int wl = start - (start % wb);
    int a;
    logic [3:0] m = '0;
    if (burst == 0)      a = start;
    else if (n == 0)     a = start;
    else if (burst == 2) a = wl + ((al - wl + n * nb) % wb);
    else                 a = al + n * nb;
    for (int x = a; x < a - (a % nb) + nb; x++) m[x % BB] = 1'b1;
    return m;
  endfunction

  task automatic run_burst(input int addr, input int size, input int burst, input int len,
                           input bit fix, input bit ones, input string tag);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_size = 3'(size);
    cmd_burst = 2'(burst); cmd_len = 8'(len); cmd_fix = fix;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R8 busy after command", cmd_ready, 0);
    for (int n = 0; n <= len; n++) begin
      logic [3:0] s, e;
      while (!in_ready) @(negedge clk);
      s = ones ? 4'hF : 4'($urandom);
      e = fix ? (s & legal(addr, size, burst, len, n)) : s;
      exp_q.push_back({(n == len), e});
      tag_q.push_back(tag);
      in_valid = 1'b1; in_strb = s;
      @(negedge clk);
      in_valid = 1'b0;
      if (n == len) chk(cmd_ready == 1'b1, "R8 idle after last", cmd_ready, 1);
      else if (n == 0) chk(cmd_ready == 1'b0, "R8 open mid burst", cmd_ready, 0);
    end
  endtask

  // Random backpressure, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = ($urandom % 4) != 0;
    end
  end

  // Monitor / scoreboard
  logic       stalled = 1'b0;
  logic [3:0] held_s;
  logic       held_l;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        chk(out_valid && out_strb == held_s && out_last == held_l,
            "R9 stall hold", {out_valid, out_last, out_strb}, {1'b1, held_l, held_s});
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected beat", out_strb, 0);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_last, out_strb} == e, t, {out_last, out_strb}, e);
        end
      end
      stalled = out_valid && !out_ready;
      held_s  = out_strb;
      held_l  = out_last;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 reset cmd_ready", cmd_ready, 1);
    chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R10 reset in_ready", in_ready, 0);
    rst_n = 1'b1;

    run_burst(32'h01, 1, 1, 2, 1'b1, 1'b1, "R3 R4 R5 unaligned halfword INCR");
    run_burst(32'h01, 1, 1, 2, 1'b1, 1'b0, "R1 masked random strobes");
    run_burst(32'h01, 0, 1, 4, 1'b0, 1'b0, "R2 bypass");
    run_burst(32'h00, 0, 1, 5, 1'b1, 1'b1, "R5 narrow byte INCR");
    run_burst(32'h03, 2, 1, 2, 1'b1, 1'b1, "R4 R5 unaligned full width");
    run_burst(32'h05, 1, 0, 3, 1'b1, 1'b1, "R6 FIXED repeat");
    run_burst(32'h06, 0, 0, 2, 1'b1, 1'b0, "R6 FIXED random");
    run_burst(32'h03, 0, 2, 1, 1'b1, 1'b1, "R7 WRAP byte window 2");
    run_burst(32'h06, 1, 2, 3, 1'b1, 1'b0, "R7 WRAP halfword random");
    run_burst(32'h2A, 1, 2, 1, 1'b1, 1'b1, "R7 WRAP halfword window 4");
    run_burst(32'h02, 3, 1, 1, 1'b1, 1'b1, "R5 oversize clamped");
    for (int k = 0; k < 20; k++) begin
      int b = $urandom % 3;
      int l = (b == 2) ? ((1 << ($urandom % 4)) - 1) : ($urandom % 9);
      int s = $urandom % 3;
      int a = $urandom % 64;
      if (b == 2) a = a - (a % (1 << s));
      run_burst(a, s, b, l, 1'($urandom), 1'($urandom), "R1 R2 random burst");
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule